// File: doc/BRIEF.md
# Locked Transaction Sequence Tracker

This block follows one legacy locked-transaction sequence through a packet switch. It watches the request and message types that have already been decoded at the port facing the root. From those it works out whether a lock is being requested, has been granted, or is absent. It also remembers which downstream port the locked path runs to. Neighbouring port logic reads the one-hot port vector and the busy flag to decide which traffic must be held back. That blocking is not part of this block.

A sequence opens when the root sends a locked memory read. The lock counts as established only once that read returns a successful locked completion with data. An unlock message ends the sequence. Only one sequence can exist at a time. A locked read that arrives while a sequence is open joins that sequence and does not start a new one.

Top module: `lock_seq_tracker`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic, `lock_state` is 2'b00 (idle), `lock_busy` is 0 and `lock_port_oh` is all zero.
- R2: In idle, a valid locked read (`tlp_kind` 2'b01) that names a port index below NUM_PORTS moves the tracker to pending (2'b01). It also records that port, so that bit `tlp_port` of `lock_port_oh` is the only bit set.
- R3: In idle, a locked read that names a port index of NUM_PORTS or above is ignored, and the tracker stays idle.
- R4: While pending or locked, a locked read changes neither the state nor the recorded port, whatever port it names. While locked, a locked completion (`tlp_kind` 2'b10) changes nothing.
- R5: In pending, a locked completion with `tlp_cpl_ok` high moves the tracker to locked (2'b10) and keeps the recorded port.
- R6: In pending, a locked completion with `tlp_cpl_ok` low returns the tracker to idle and clears the port vector.
- R7: An unlock message (`tlp_kind` 2'b11) in pending or locked returns the tracker to idle and clears the port vector.
- R8: In idle, an unlock message or a locked completion has no effect.
- R9: When `tlp_valid` is low, or when the kind is 2'b00 (other traffic), the state and the port vector do not change.
- R10: `lock_busy` is high exactly when the state is not idle. `lock_port_oh` has exactly one bit set while busy and no bit set while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tlp_valid | input | 1 | A decoded packet is present this cycle |
| tlp_kind | input | 2 | 00 other, 01 locked read, 10 locked completion, 11 unlock |
| tlp_cpl_ok | input | 1 | Completion status is successful (used with kind 10) |
| tlp_port | input | PORT_W | Downstream port targeted by a locked read |
| lock_state | output | 2 | 00 idle, 01 pending, 10 locked |
| lock_busy | output | 1 | A lock sequence is pending or established |
| lock_port_oh | output | NUM_PORTS | One-hot downstream port holding the lock |

## Verification
Every state and port-vector change appears on the outputs one cycle after the clock edge that samples the packet. There are no further register stages, so `lock_busy` follows in the same cycle as `lock_state`. The bench drives each packet on a falling edge and updates its own model at the next rising edge. It compares all outputs at the falling edge after that, so every comparison lands in the cycle the result is due. After reset is released, the internal two-stage synchronizer holds the tracker idle for two more cycles. The bench waits longer than that before it sends any traffic.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic [1:0] {
    K_OTHER  = 2'b00,
    K_RDLK   = 2'b01,
    K_CPLLK  = 2'b10,
    K_UNLOCK = 2'b11
  } tlp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_LOCK = 2'b10
  } lock_state_e;

endpackage

// File: rtl/lk_rst_sync.sv
module lk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/lk_evt_decode.sv
module lk_evt_decode #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 2
) (
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic              in_ok,
  input  logic [PORT_W-1:0] in_port,
  output logic              ev_req,
  output logic              ev_grant,
  output logic              ev_fail,
  output logic              ev_release
);
  import lk_pkg::*;

  localparam logic [PORT_W:0] PORT_LIMIT = (PORT_W+1)'(NUM_PORTS);

  logic port_in_range;
  logic is_cpl;

  // Reject port indices that name no real downstream port.
  assign port_in_range = ({1'b0, in_port} < PORT_LIMIT);
  assign is_cpl        = in_valid && (in_kind == K_CPLLK);

  assign ev_req     = in_valid && (in_kind == K_RDLK) && port_in_range;
  assign ev_grant   = is_cpl && in_ok;
  assign ev_fail    = is_cpl && !in_ok;
  assign ev_release = in_valid && (in_kind == K_UNLOCK);

endmodule

// File: rtl/lk_fsm.sv
module lk_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_req,
  input  logic                ev_grant,
  input  logic                ev_fail,
  input  logic                ev_release,
  output lk_pkg::lock_state_e state_q,
  output logic                capture,
  output logic                clear
);
  import lk_pkg::*;

  lock_state_e state_d;
  logic        state_en;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    clear   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ev_req) begin
          state_d = ST_PEND;
          capture = 1'b1;
        end
      end
      ST_PEND: begin
        // Release or failure wins over a grant; both cannot occur together.
        if (ev_release || ev_fail) begin
          state_d = ST_IDLE;
          clear   = 1'b1;
        end else if (ev_grant) begin
          state_d = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (ev_release) begin
          state_d = ST_IDLE;
          clear   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        clear   = 1'b1;
      end
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/lk_port_reg.sv
module lk_port_reg #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic                 clear,
  input  logic [PORT_W-1:0]    in_port,
  output logic [NUM_PORTS-1:0] port_oh
);

  logic [PORT_W-1:0] idx_q;
  logic [PORT_W-1:0] idx_d;
  logic              held_q;
  logic              held_d;
  logic              load_en;

  assign load_en = capture || clear;

  always_comb begin
    idx_d  = '0;
    held_d = 1'b0;
    if (capture) begin
      idx_d  = in_port;
      held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      held_q <= 1'b0;
    end else if (load_en) begin
      idx_q  <= idx_d;
      held_q <= held_d;
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_oh
    assign port_oh[g] = held_q && (idx_q == PORT_W'(g));
  end

endmodule

// File: rtl/lock_seq_tracker.sv
module lock_seq_tracker #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tlp_valid,
  input  logic [1:0]           tlp_kind,
  input  logic                 tlp_cpl_ok,
  input  logic [PORT_W-1:0]    tlp_port,
  output logic [1:0]           lock_state,
  output logic                 lock_busy,
  output logic [NUM_PORTS-1:0] lock_port_oh
);
  import lk_pkg::*;

  logic        rst_sync_n;
  logic        ev_req;
  logic        ev_grant;
  logic        ev_fail;
  logic        ev_release;
  logic        capture;
  logic        clear;
  lock_state_e state_q;

  lk_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lk_evt_decode #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) i_decode (
    .in_valid   (tlp_valid),
    .in_kind    (tlp_kind),
    .in_ok      (tlp_cpl_ok),
    .in_port    (tlp_port),
    .ev_req     (ev_req),
    .ev_grant   (ev_grant),
    .ev_fail    (ev_fail),
    .ev_release (ev_release)
  );

  lk_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_req     (ev_req),
    .ev_grant   (ev_grant),
    .ev_fail    (ev_fail),
    .ev_release (ev_release),
    .state_q    (state_q),
    .capture    (capture),
    .clear      (clear)
  );

  lk_port_reg #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) i_port (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (capture),
    .clear   (clear),
    .in_port (tlp_port),
    .port_oh (lock_port_oh)
  );

  assign lock_state = state_q;
  assign lock_busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/lock_seq_tracker_chk.sv
module lock_seq_tracker_chk #(
  parameter int NUM_PORTS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tlp_valid,
  input logic [1:0]           tlp_kind,
  input logic                 tlp_cpl_ok,
  input logic [1:0]           lock_state,
  input logic                 lock_busy,
  input logic [NUM_PORTS-1:0] lock_port_oh
);

  AST_BUSY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |-> ($countones(lock_port_oh) == 1)); // R10

  AST_IDLE_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_busy |-> (lock_port_oh == '0)); // R10

  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_busy && $past(lock_busy)) |-> $stable(lock_port_oh)); // R4

  AST_LOCK_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 2'b10 && $past(lock_state) != 2'b10) |->
      ($past(lock_state) == 2'b01 && $past(tlp_valid && tlp_kind == 2'b10 && tlp_cpl_ok))); // R5

  AST_FAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 2'b01 && tlp_valid && tlp_kind == 2'b10 && !tlp_cpl_ok) |=> (lock_state == 2'b00)); // R6

  AST_UNLOCK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_busy && tlp_valid && tlp_kind == 2'b11) |=> !lock_busy); // R7

  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 2'b00 && tlp_valid && (tlp_kind == 2'b10 || tlp_kind == 2'b11)) |=> (lock_state == 2'b00)); // R8

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlp_valid || tlp_kind == 2'b00) |=> $stable(lock_state)); // R9

endmodule

bind lock_seq_tracker lock_seq_tracker_chk #(
  .NUM_PORTS (NUM_PORTS)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tlp_valid    (tlp_valid),
  .tlp_kind     (tlp_kind),
  .tlp_cpl_ok   (tlp_cpl_ok),
  .lock_state   (lock_state),
  .lock_busy    (lock_busy),
  .lock_port_oh (lock_port_oh)
);

// File: tb/test_lock_seq_tracker.sv
`timescale 1ns/1ps
module test_lock_seq_tracker;

  localparam int NP = 3;
  localparam int PW = 2;

  logic          clk;
  logic          rst_n;
  logic          tlp_valid;
  logic [1:0]    tlp_kind;
  logic          tlp_cpl_ok;
  logic [PW-1:0] tlp_port;
  logic [1:0]    lock_state;
  logic          lock_busy;
  logic [NP-1:0] lock_port_oh;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int m_state = 0;
  int m_port  = 0;

  lock_seq_tracker #(.NUM_PORTS(NP)) i_lock_seq_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tlp_valid    (tlp_valid),
    .tlp_kind     (tlp_kind),
    .tlp_cpl_ok   (tlp_cpl_ok),
    .tlp_port     (tlp_port),
    .lock_state   (lock_state),
    .lock_busy    (lock_busy),
    .lock_port_oh (lock_port_oh)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NP-1:0] exp_oh();
    if (m_state == 0) return '0;
    return NP'(1) << m_port;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk(tag, {3'b0, lock_state, lock_port_oh}, {3'b0, 2'(m_state), exp_oh()});
    chk("R10", {7'b0, lock_busy}, {7'b0, (m_state != 0)});
  endtask

  // Model update for one sampled packet; returns the requirement it exercises.
  function automatic string model(input bit v, input logic [1:0] k, input bit ok, input int p);
    if (!v || k == 2'b00) return "R9";
    case (k)
      2'b01: begin
        if (m_state != 0) return "R4";
        if (p >= NP) return "R3";
        m_state = 1; m_port = p; return "R2";
      end
      2'b10: begin
        if (m_state == 1) begin
          if (ok) begin m_state = 2; return "R5"; end
          m_state = 0; return "R6";
        end
        if (m_state == 2) return "R4";
        return "R8";
      end
      default: begin
        if (m_state != 0) begin m_state = 0; return "R7"; end
        return "R8";
      end
    endcase
  endfunction

  task automatic step(input bit v, input logic [1:0] k, input bit ok, input int p);
    string tag;
    tlp_valid  = v;
    tlp_kind   = k;
    tlp_cpl_ok = ok;
    tlp_port   = PW'(p);
    @(posedge clk);
    tag = model(v, k, ok, p);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; tlp_valid = 1'b0; tlp_kind = 2'b00; tlp_cpl_ok = 1'b0; tlp_port = '0;
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R1");

    // Directed corner cases
    step(1, 2'b11, 0, 0);   // R8 unlock in idle
    step(1, 2'b10, 1, 0);   // R8 completion in idle
    step(1, 2'b01, 0, 3);   // R3 out-of-range port
    step(0, 2'b01, 0, 1);   // R9 not valid
    step(1, 2'b01, 0, 2);   // R2 start on port 2
    step(1, 2'b01, 0, 0);   // R4 second read while pending
    step(1, 2'b00, 1, 1);   // R9 other traffic
    step(1, 2'b10, 1, 1);   // R5 grant
    step(1, 2'b01, 0, 1);   // R4 read while locked
    step(1, 2'b10, 0, 0);   // R4 completion while locked
    step(1, 2'b11, 0, 0);   // R7 unlock from locked
    step(1, 2'b01, 0, 1);   // R2 start on port 1
    step(1, 2'b10, 0, 1);   // R6 failed completion
    step(1, 2'b01, 0, 0);   // R2 start on port 0
    step(1, 2'b11, 0, 2);   // R7 unlock from pending

    // Asynchronous reset while locked
    step(1, 2'b01, 0, 1);
    step(1, 2'b10, 1, 0);
    #3 rst_n = 1'b0;
    #1 m_state = 0; m_port = 0;
    check_outputs("R1");
    tlp_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R1");

    // Constrained random traffic
    for (int i = 0; i < 600; i++) begin
      bit v;
      logic [1:0] k;
      bit ok;
      r  = int'($urandom_range(0, 99));
      v  = (r < 85);
      k  = 2'($urandom_range(0, 3));
      ok = ($urandom_range(0, 9) < 7);
      step(v, k, ok, int'($urandom_range(0, 3)));
    end

    finish_run();
  end

endmodule